// File: doc/BRIEF.md
# JTAG Instruction Register and Data-Register Path

This block is the test-logic core behind a JTAG port. An external TAP state machine, treated as already verified, supplies TCK and a one-hot set of state strobes (Test-Logic-Reset, Capture/Shift/Update for the instruction and data columns). The core holds a 4-bit instruction shift stage and an active instruction. It decodes the active opcode to choose which data register sits between TDI and TDO. All shift stages move least-significant bit first. All state changes on the rising edge of TCK while the matching strobe is high.

Three paths are provided. The first is a 32-bit identification register. It carries a version field, a device-number field and a manufacturer code above a fixed 1 in bit 0, and it is the instruction in force after reset. The second is a one-bit reset register. Its flip-flop output is not held behind an update stage: it is ORed with the chip's other reset sources and forms a system reset request as soon as a 1 is shifted in. Because every port pin resets to tri-state, loading this instruction and shifting in a 1 is also how outputs are floated. The third is a select-and-strobe port toward an external boundary-scan chain, whose serial output is returned on a dedicated input.

Top module: `jtag_test_core`

## Requirements
- R1: While `trst_n` is low, or on a TCK edge with `tlr` high, the active instruction becomes 0x1 (identification) and the reset flip-flop clears. A Capture-DR/Shift-DR sequence then returns the identification value.
- R2: On a TCK edge with `capture_ir` high, the instruction shift stage loads 4'b0001. Each edge with `shift_ir` high shifts it right, taking `tdi` into bit 3. While `shift_ir` is high, `tdo` is bit 0 of the stage.
- R3: On a TCK edge with `update_ir` high, the shifted value becomes the active instruction. The new path applies from the next cycle on.
- R4: With opcode 0x1 active, Capture-DR loads the identification value. Each following Shift-DR edge moves it one place, and `tdo` shows its bits from bit 0 to bit 31.
- R5: The identification value holds 1 in bit 0, the manufacturer code in bits 11:1, the device number in bits 27:12 and the version in bits 31:28, each field set by a parameter.
- R6: With opcode 0x0 active, `bsc_select` is high. `bsc_capture`, `bsc_shift` and `bsc_update` follow `capture_dr`, `shift_dr` and `update_dr`, and during Shift-DR `tdo` equals `bsc_tdo`. With any other opcode, all four outputs stay low.
- R7: With opcode 0xC active, each Shift-DR edge loads `tdi` into the reset flip-flop, and during Shift-DR `tdo` shows that flip-flop.
- R8: `sys_rst_req` is the OR of `ext_rst_req` and the reset flip-flop. It follows a shifted-in 1 from the edge that loads it, and an Update-DR strobe does not change it.
- R9: Any opcode other than 0x0, 0x1 and 0xC selects the identification register, exactly as 0x1 does.
- R10: The reset flip-flop keeps its value on every edge without Shift-DR under opcode 0xC, including after the instruction changes. Only the R1 conditions clear it.
- R11: `tdo_en` is high exactly while `shift_ir` or `shift_dr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic reset, active low |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| capture_ir | input | 1 | TAP is in Capture-IR |
| shift_ir | input | 1 | TAP is in Shift-IR |
| update_ir | input | 1 | TAP is in Update-IR |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial test data in |
| bsc_tdo | input | 1 | Serial output of the external boundary chain |
| ext_rst_req | input | 1 | Other internal and external reset sources, ORed |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | High while a shift state drives `tdo` |
| bsc_select | output | 1 | Boundary chain is the selected data path |
| bsc_capture | output | 1 | Capture strobe for the boundary chain |
| bsc_shift | output | 1 | Shift strobe for the boundary chain |
| bsc_update | output | 1 | Update strobe for the boundary chain |
| sys_rst_req | output | 1 | System reset request |

## Verification
The bench builds the core with version 0xA, device number 0x5A3C and manufacturer code 0x2B5 instead of the defaults. These values put both 0s and 1s in every field, so a field placed at the wrong offset or shifted out in the wrong order shows up in the assembled 32-bit word. The bench walks through all three named opcodes and two unused ones (0x7, 0xF). It sets the reset bit and holds it across Update-DR and an instruction change, then clears the core by Test-Logic-Reset and by the asynchronous reset. An eight-bit external chain model preloaded with 0xA5 lets the boundary path be told apart from the other two.

// File: rtl/jtagc_pkg.sv
package jtagc_pkg;

  localparam int IR_W = 4;

  // opcodes whose meaning is fixed by the instruction decode
  localparam logic [IR_W-1:0] OP_BSCAN = 4'h0;
  localparam logic [IR_W-1:0] OP_IDENT = 4'h1;
  localparam logic [IR_W-1:0] OP_RESET = 4'hC;

  // pattern captured into the instruction stage (two LSBs 01)
  localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 4'b0001;

  typedef enum logic [1:0] {
    PATH_IDENT = 2'd0,
    PATH_BSCAN = 2'd1,
    PATH_RESET = 2'd2
  } dr_path_e;

  // opcode -> data path; anything unlisted falls to identification
  function automatic dr_path_e decode_opcode(logic [IR_W-1:0] op);
    dr_path_e p;
    case (op)
      OP_BSCAN: p = PATH_BSCAN;
      OP_RESET: p = PATH_RESET;
      default:  p = PATH_IDENT;
    endcase
    return p;
  endfunction

  // identification word: version | device | manufacturer | 1
  function automatic logic [31:0] make_ident(logic [3:0] ver, logic [15:0] dev,
                                             logic [10:0] mfr);
    return {ver, dev, mfr, 1'b1};
  endfunction

endpackage

// File: rtl/jtagc_ir.sv
module jtagc_ir
  import jtagc_pkg::*;
#(
  parameter int              W        = IR_W,
  parameter logic [W-1:0]    RESET_OP = OP_IDENT,
  parameter logic [W-1:0]    CAPT_VAL = IR_CAPTURE_VAL
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tlr,
  input  logic         capture,
  input  logic         shift,
  input  logic         update,
  input  logic         tdi,
  output logic         ir_so,
  output logic [W-1:0] active
);

  logic [W-1:0] stage_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      stage_q <= CAPT_VAL;
      active  <= RESET_OP;
    end else if (tlr) begin
      stage_q <= CAPT_VAL;
      active  <= RESET_OP;
    end else begin
      if (capture)
        stage_q <= CAPT_VAL;
      else if (shift)
        stage_q <= {tdi, stage_q[W-1:1]};
      if (update)
        active <= stage_q;
    end
  end

  assign ir_so = stage_q[0];

  // R1
  tlr_default_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> active == RESET_OP);

  // R2
  ir_shift_in_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (shift && !capture && !tlr) |=> stage_q[W-1] == $past(tdi));

  // R3
  ir_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (update && !tlr) |=> active == $past(stage_q));

endmodule

// File: rtl/jtagc_idreg.sv
module jtagc_idreg #(
  parameter int           W     = 32,
  parameter logic [W-1:0] VALUE = '1
) (
  input  logic tck,
  input  logic trst_n,
  input  logic capture,
  input  logic shift,
  input  logic tdi,
  output logic so
);

  logic [W-1:0] cell_q;

  // one cell per bit; capture has priority over shift
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic next_in;
    if (i == W - 1) begin : g_top
      assign next_in = tdi;
    end else begin : g_mid
      assign next_in = cell_q[i+1];
    end
    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)      cell_q[i] <= VALUE[i];
      else if (capture) cell_q[i] <= VALUE[i];
      else if (shift)   cell_q[i] <= next_in;
    end
  end

  assign so = cell_q[0];

  // R4
  id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    capture |=> so == VALUE[0]);

  // R4
  id_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (shift && !capture) |=> cell_q[W-1] == $past(tdi));

endmodule

// File: rtl/jtagc_rstreg.sv
module jtagc_rstreg (
  input  logic tck,
  input  logic trst_n,
  input  logic tlr,
  input  logic shift,
  input  logic tdi,
  output logic q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    q <= 1'b0;
    else if (tlr)   q <= 1'b0;
    else if (shift) q <= tdi;
  end

  // R7
  rst_load_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (shift && !tlr) |=> q == $past(tdi));

  // R10
  rst_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!shift && !tlr) |=> $stable(q));

endmodule

// File: rtl/jtag_test_core.sv
module jtag_test_core
  import jtagc_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_DEVICE  = 16'h9781,
  parameter logic [10:0] ID_MFR     = 11'h01F
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tlr,
  input  logic capture_ir,
  input  logic shift_ir,
  input  logic update_ir,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic tdi,
  input  logic bsc_tdo,
  input  logic ext_rst_req,
  output logic tdo,
  output logic tdo_en,
  output logic bsc_select,
  output logic bsc_capture,
  output logic bsc_shift,
  output logic bsc_update,
  output logic sys_rst_req
);

  localparam int          ID_W     = 32;
  localparam logic [31:0] ID_VALUE = make_ident(ID_VERSION, ID_DEVICE, ID_MFR);

  logic [IR_W-1:0] active_op;
  logic            ir_so;
  logic            id_so;
  logic            rst_q;
  dr_path_e        path;

  // named per-path strobes
  logic sel_id, sel_bsc, sel_rst;
  logic id_capture, id_shift, rst_shift;

  jtagc_ir #(
    .W        (IR_W),
    .RESET_OP (OP_IDENT),
    .CAPT_VAL (IR_CAPTURE_VAL)
  ) u_ir (
    .tck     (tck),
    .trst_n  (trst_n),
    .tlr     (tlr),
    .capture (capture_ir),
    .shift   (shift_ir),
    .update  (update_ir),
    .tdi     (tdi),
    .ir_so   (ir_so),
    .active  (active_op)
  );

  assign path    = decode_opcode(active_op);
  assign sel_id  = (path == PATH_IDENT);
  assign sel_bsc = (path == PATH_BSCAN);
  assign sel_rst = (path == PATH_RESET);

  assign id_capture = capture_dr & sel_id;
  assign id_shift   = shift_dr & sel_id;
  assign rst_shift  = shift_dr & sel_rst;

  jtagc_idreg #(
    .W     (ID_W),
    .VALUE (ID_VALUE)
  ) u_id (
    .tck     (tck),
    .trst_n  (trst_n),
    .capture (id_capture),
    .shift   (id_shift),
    .tdi     (tdi),
    .so      (id_so)
  );

  jtagc_rstreg u_rst (
    .tck    (tck),
    .trst_n (trst_n),
    .tlr    (tlr),
    .shift  (rst_shift),
    .tdi    (tdi),
    .q      (rst_q)
  );

  // boundary chain select and gated strobes
  assign bsc_select  = sel_bsc;
  assign bsc_capture = capture_dr & sel_bsc;
  assign bsc_shift   = shift_dr & sel_bsc;
  assign bsc_update  = update_dr & sel_bsc;

  // reset request is not behind an update stage
  assign sys_rst_req = rst_q | ext_rst_req;

  // serial output mux
  always_comb begin
    if (shift_ir) begin
      tdo = ir_so;
    end else begin
      unique case (path)
        PATH_BSCAN: tdo = bsc_tdo;
        PATH_RESET: tdo = rst_q;
        default:    tdo = id_so;
      endcase
    end
  end

  assign tdo_en = shift_ir | shift_dr;

  // R6
  bsc_gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (bsc_capture || bsc_shift || bsc_update) |-> bsc_select);

  // R9
  path_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot({sel_id, sel_bsc, sel_rst}));

  // R8
  rst_out_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(rst_q) |-> sys_rst_req);

  // R8
  rst_cause_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(rst_q) |-> $past(rst_shift && tdi));

endmodule

// File: tb/jtag_test_core_test.sv
module jtag_test_core_test;

  localparam logic [3:0]  T_VER = 4'hA;
  localparam logic [15:0] T_DEV = 16'h5A3C;
  localparam logic [10:0] T_MFR = 11'h2B5;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tlr = 0, cap_ir = 0, sh_ir = 0, up_ir = 0;
  logic cap_dr = 0, sh_dr = 0, up_dr = 0, tdi = 0, ext_rst = 0;
  logic bsc_tdo;
  logic tdo, tdo_en, bsc_select, bsc_capture, bsc_shift, bsc_update, sys_rst_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 tck = ~tck;

  jtag_test_core #(
    .ID_VERSION (T_VER),
    .ID_DEVICE  (T_DEV),
    .ID_MFR     (T_MFR)
  ) uut (
    .tck         (tck),
    .trst_n      (trst_n),
    .tlr         (tlr),
    .capture_ir  (cap_ir),
    .shift_ir    (sh_ir),
    .update_ir   (up_ir),
    .capture_dr  (cap_dr),
    .shift_dr    (sh_dr),
    .update_dr   (up_dr),
    .tdi         (tdi),
    .bsc_tdo     (bsc_tdo),
    .ext_rst_req (ext_rst),
    .tdo         (tdo),
    .tdo_en      (tdo_en),
    .bsc_select  (bsc_select),
    .bsc_capture (bsc_capture),
    .bsc_shift   (bsc_shift),
    .bsc_update  (bsc_update),
    .sys_rst_req (sys_rst_req)
  );

  // external boundary chain: driven by the core's strobes, preloads 0xA5
  logic [7:0] chain;
  always @(posedge tck) begin
    if (bsc_capture) chain <= 8'hA5;
    else if (bsc_shift) chain <= {tdi, chain[7:1]};
  end
  initial chain = 8'h00;
  assign bsc_tdo = chain[0];

  // expected ident computed arithmetically
  longint unsigned exp_id;
  initial exp_id = longint'(T_VER) * 268435456 + longint'(T_DEV) * 4096
                 + longint'(T_MFR) * 2 + 1;

  // reference model
  int m_irsh, m_ir, m_rst;
  longint unsigned m_id;
  bit m_chain_q[$];

  function automatic int mode_of(int op);
    if (op == 0) return 1;       // boundary
    if (op == 12) return 2;      // reset bit
    return 0;                    // identification
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      m_irsh = 1; m_ir = 1; m_rst = 0; m_id = exp_id;
    end else if (tlr) begin
      m_irsh = 1; m_ir = 1; m_rst = 0;
      if (cap_dr) m_id = exp_id;
      else if (sh_dr) m_id = (m_id >> 1) + (tdi ? 64'h80000000 : 0);
    end else begin
      int md;
      md = mode_of(m_ir);
      if (cap_dr && md == 0) m_id = exp_id;
      else if (sh_dr && md == 0) m_id = (m_id >> 1) + (tdi ? 64'h80000000 : 0);
      if (sh_dr && md == 2) m_rst = tdi;
      if (cap_ir) m_irsh = 1;
      else if (sh_ir) m_irsh = (m_irsh >> 1) + (tdi ? 8 : 0);
      if (up_ir) m_ir = m_irsh;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison of every output against the model
  task automatic compare_all();
    int md, e_tdo;
    md = mode_of(m_ir);
    if (sh_ir) e_tdo = m_irsh % 2;
    else if (md == 1) e_tdo = int'(chain[0]);
    else if (md == 2) e_tdo = m_rst;
    else e_tdo = int'(m_id % 2);
    chk(sh_ir ? "R2 tdo" : (md == 1 ? "R6 tdo" : (md == 2 ? "R7 tdo" : "R4 tdo")),
        int'(tdo), e_tdo);
    chk("R11 tdo_en", int'(tdo_en), int'(sh_ir | sh_dr));
    chk("R6 select", int'(bsc_select), int'(md == 1));
    chk("R6 strobes", {29'd0, bsc_capture, bsc_shift, bsc_update},
        (md == 1) ? {29'd0, cap_dr, sh_dr, up_dr} : 0);
    chk("R8 sys_rst_req", int'(sys_rst_req), int'(m_rst == 1 || ext_rst));
  endtask

  task automatic step(input logic c_ir, s_ir, u_ir, c_dr, s_dr, u_dr, t, d);
    @(negedge tck);
    cap_ir = c_ir; sh_ir = s_ir; up_ir = u_ir;
    cap_dr = c_dr; sh_dr = s_dr; up_dr = u_dr; tlr = t; tdi = d;
    #1 compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load_ir(input int op);
    int cap;
    cap = 0;
    step(1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 0, 0, 0, 0, 0, logic'((op >> i) & 1));
      cap += int'(tdo) << i;
    end
    chk("R2 captured IR pattern", cap, 1);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    idle();
  endtask

  task automatic read_dr(input int n, input longint unsigned din,
                         output longint unsigned dout);
    dout = 0;
    step(0, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 1, 0, 0, logic'((din >> i) & 1));
      dout += longint'(tdo) << i;
    end
    step(0, 0, 0, 0, 0, 1, 0, 0);
    idle();
  endtask

  // watchdog
  always @(posedge tck) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    longint unsigned w;
    #1 trst_n = 0;
    #10;
    // R1 reset state
    chk("R1 sys_rst at reset", int'(sys_rst_req), 0);
    chk("R1 select at reset", int'(bsc_select), 0);
    @(negedge tck) trst_n = 1;
    idle(); idle();

    // R1 R4 R5 default identification
    read_dr(32, 64'h0, w);
    chk("R4 ident word", int'(w), int'(exp_id));
    chk("R5 bit0", int'(w & 1), 1);
    chk("R5 mfr field", int'((w >> 1) & 11'h7FF), int'(T_MFR));
    chk("R5 device field", int'((w >> 12) & 16'hFFFF), int'(T_DEV));
    chk("R5 version field", int'((w >> 28) & 4'hF), int'(T_VER));

    // R6 boundary chain
    load_ir(0);
    chk("R6 select after update", int'(bsc_select), 1);
    read_dr(8, 64'h3C, w);
    chk("R6 chain data", int'(w), 32'hA5);

    // R7 R8 reset register
    load_ir(12);
    step(0, 0, 0, 0, 1, 0, 0, 1);
    idle();
    chk("R8 reset follows shifted 1", int'(sys_rst_req), 1);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 unchanged by update", int'(sys_rst_req), 1);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    idle();
    chk("R7 cleared by shifted 0", int'(sys_rst_req), 0);
    step(0, 0, 0, 0, 1, 0, 0, 1);
    idle();
    // R10 held across instruction change
    load_ir(1);
    chk("R10 reset held after IR change", int'(sys_rst_req), 1);
    read_dr(32, 64'hFFFFFFFF, w);
    chk("R10 held during ident shift", int'(sys_rst_req), 1);
    // R1 tlr clears
    step(0, 0, 0, 0, 0, 0, 1, 0);
    idle();
    chk("R1 tlr clears reset bit", int'(sys_rst_req), 0);

    // R8 external source
    @(negedge tck) ext_rst = 1;
    #1 chk("R8 external reset passes", int'(sys_rst_req), 1);
    idle();
    @(negedge tck) ext_rst = 0;
    idle();

    // R9 unused opcodes
    load_ir(7);
    read_dr(32, 64'h0, w);
    chk("R9 opcode 7 reads ident", int'(w), int'(exp_id));
    load_ir(15);
    read_dr(32, 64'h0, w);
    chk("R9 opcode F reads ident", int'(w), int'(exp_id));

    // R1 tlr after boundary select
    load_ir(0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    idle();
    chk("R1 tlr restores ident", int'(bsc_select), 0);
    read_dr(32, 64'h0, w);
    chk("R1 ident after tlr", int'(w), int'(exp_id));

    // R1 async reset clears reset bit and IR
    load_ir(12);
    step(0, 0, 0, 0, 1, 0, 0, 1);
    idle();
    @(negedge tck) trst_n = 0;
    #1 chk("R1 trst clears reset bit", int'(sys_rst_req), 0);
    @(negedge tck) trst_n = 1;
    idle();
    read_dr(32, 64'h0, w);
    chk("R1 ident after trst", int'(w), int'(exp_id));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule